// File: doc/BRIEF.md
# Frame Sync Search/Lock Detector

This block watches a serial received bit stream, one bit per asserted `bit_en`, and finds the 11-bit Barker synchronization word that marks frame boundaries. After reset it hunts for the word at every bit position. Lock is declared only when a second word arrives exactly one frame period after the first. Once locked, it examines just the expected word position in each frame and tolerates a limited run of misses before falling back to hunting.

While locked on the control-channel timing, the block also picks the channel busy/idle bits out of the frame. These sit every 11 bits, starting at the bit right after the sync word. It reports the majority of the three most recent ones. A mode input selects the control-channel timing (463-bit frame, five misses allowed) or the voice-channel timing (88-bit frame, two misses allowed). Downstream blocks use the `frame_start` pulse as their frame reference.

Top module: `fsd_frame_sync`

## Requirements
- R1: A synchronous active-high `rst` leaves the block hunting, with `locked`, `sync_strobe`, `frame_start` and `busy_status` all low, and the busy/idle history cleared.
- R2: The sync word is 11100010010, compared against the 11 most recent bits with the earliest received bit as the MSB. While hunting, every bit position is compared, and a match raises `sync_strobe` for one cycle in the cycle after the enabled bit that completes the word.
- R3: Lock is entered only when a second word ends exactly one frame period after the first one ends (463 bits in control mode). A word seen at any other spacing while waiting restarts the wait from that word. `locked` rises in the cycle after the second word's last bit.
- R4: While locked, only the expected word position is compared. A word completing anywhere else produces no `sync_strobe`.
- R5: In control mode, 5 consecutive misses at expected positions drop `locked`. Four misses keep it, and a hit clears the run of misses.
- R6: `frame_start` pulses on lock entry and at every expected position while lock is held, whether the word is hit or a tolerated miss. It does not pulse on the miss that drops lock, and it never pulses while unlocked.
- R7: Busy/idle bits are sampled only in control mode while locked, at bit offsets 1, 12, 23, … after the last bit of the reference word. All other bits, and all bits seen while hunting, leave the history unchanged.
- R8: `busy_status` is the majority of the last three sampled busy/idle bits (1 = busy). It updates in the cycle after the sampled bit.
- R9: In voice mode (`voice_mode` = 1) the frame period is 88 bits, two consecutive misses drop lock, and no busy/idle bits are sampled.
- R10: Clock cycles with `bit_en` low do not advance the block. Outputs hold, except that the strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `bit_in` as a new received bit |
| bit_in | input | 1 | Received serial data bit |
| voice_mode | input | 1 | 0 = control-channel timing, 1 = voice-channel timing; held steady between resets |
| locked | output | 1 | High while frame lock is held |
| sync_strobe | output | 1 | One-cycle pulse for each accepted sync word |
| frame_start | output | 1 | One-cycle pulse at each frame boundary while locked |
| busy_status | output | 1 | Majority-decided channel busy/idle status |

## Verification
On every cycle, the assertions check several properties:
- idle `bit_en` cycles freeze the block;
- `frame_start` never appears unlocked;
- lock entry coincides with an accepted word;
- dropping lock is silent;
- reset clears the outputs.

The exact spacings need the bench's scenarios, because they depend on the stream: one-bit-early and one-bit-late second words, the four-versus-five miss boundary and the recovery on a hit. So do the blindness to off-position words, the placement of the busy/idle sample points and the majority results over chosen bit patterns.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
   typedef enum logic [1:0] {
      FS_SEARCH = 2'd0,
      FS_PEND   = 2'd1,
      FS_LOCK   = 2'd2
   } fs_state_t;
endpackage

// File: rtl/fsd_sync_match.sv
module fsd_sync_match #(
   parameter int                  SYNC_LEN  = 11,
   parameter logic [SYNC_LEN-1:0] SYNC_WORD = 11'b11100010010
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_en,
   input  logic bit_in,
   output logic match
);
   localparam int HIST_W = SYNC_LEN - 1;

   logic [HIST_W-1:0] hist_q;
   logic [SYNC_LEN-1:0] window;

   // the incoming bit completes the window; earliest bit sits in the MSB
   assign window = {hist_q, bit_in};
   assign match  = bit_en && (window == SYNC_WORD);

   always_ff @(posedge clk) begin
      if (rst)
         hist_q <= '0;
      else if (bit_en)
         hist_q <= window[HIST_W-1:0];
   end
endmodule

// File: rtl/fsd_frame_ctrl.sv
module fsd_frame_ctrl
   import fsd_pkg::*;
#(
   parameter int CTRL_PERIOD  = 463,
   parameter int VOICE_PERIOD = 88,
   parameter int CTRL_MISSES  = 5,
   parameter int VOICE_MISSES = 2,
   parameter int BI_SPACING   = 11
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_en,
   input  logic voice_mode,
   input  logic match,
   output logic locked,
   output logic sync_strobe,
   output logic frame_start,
   output logic bi_sample
);
   localparam int MAX_PERIOD = (CTRL_PERIOD > VOICE_PERIOD) ? CTRL_PERIOD : VOICE_PERIOD;
   localparam int MAX_MISSES = (CTRL_MISSES > VOICE_MISSES) ? CTRL_MISSES : VOICE_MISSES;
   localparam int CNT_W      = $clog2(MAX_PERIOD + 1);
   localparam int MISS_W     = $clog2(MAX_MISSES + 1);
   localparam int BI_W       = $clog2(BI_SPACING + 1);

   localparam logic [CNT_W-1:0]  CTRL_LAST  = CNT_W'(CTRL_PERIOD - 1);
   localparam logic [CNT_W-1:0]  VOICE_LAST = CNT_W'(VOICE_PERIOD - 1);
   localparam logic [MISS_W-1:0] CTRL_FINAL = MISS_W'(CTRL_MISSES - 1);
   localparam logic [MISS_W-1:0] VOICE_FINAL = MISS_W'(VOICE_MISSES - 1);
   localparam logic [BI_W-1:0]   BI_LAST    = BI_W'(BI_SPACING - 1);

   fs_state_t         state_q;
   logic [CNT_W-1:0]  pos_q;
   logic [MISS_W-1:0] miss_q;
   logic [BI_W-1:0]   phase_q;

   logic [CNT_W-1:0]  pos_last;
   logic [MISS_W-1:0] miss_final;
   logic              at_expect;

   assign pos_last   = voice_mode ? VOICE_LAST : CTRL_LAST;
   assign miss_final = voice_mode ? VOICE_FINAL : CTRL_FINAL;
   assign at_expect  = (pos_q >= pos_last);
   assign locked     = (state_q == FS_LOCK);
   assign bi_sample  = bit_en && locked && !voice_mode && !at_expect && (phase_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q     <= FS_SEARCH;
         pos_q       <= '0;
         miss_q      <= '0;
         phase_q     <= '0;
         sync_strobe <= 1'b0;
         frame_start <= 1'b0;
      end else begin
         sync_strobe <= 1'b0;
         frame_start <= 1'b0;
         if (bit_en) begin
            pos_q   <= pos_q + 1'b1;
            phase_q <= (phase_q == BI_LAST) ? '0 : phase_q + 1'b1;
            case (state_q)
               FS_SEARCH: begin
                  if (match) begin
                     state_q     <= FS_PEND;
                     pos_q       <= '0;
                     sync_strobe <= 1'b1;
                  end
               end
               FS_PEND: begin
                  if (at_expect) begin
                     if (match) begin
                        state_q     <= FS_LOCK;
                        pos_q       <= '0;
                        phase_q     <= '0;
                        miss_q      <= '0;
                        sync_strobe <= 1'b1;
                        frame_start <= 1'b1;
                     end else begin
                        state_q <= FS_SEARCH;
                     end
                  end else if (match) begin
                     pos_q       <= '0;
                     sync_strobe <= 1'b1;
                  end
               end
               FS_LOCK: begin
                  if (at_expect) begin
                     pos_q   <= '0;
                     phase_q <= '0;
                     if (match) begin
                        miss_q      <= '0;
                        sync_strobe <= 1'b1;
                        frame_start <= 1'b1;
                     end else if (miss_q >= miss_final) begin
                        state_q <= FS_SEARCH;
                        miss_q  <= '0;
                     end else begin
                        miss_q      <= miss_q + 1'b1;
                        frame_start <= 1'b1;
                     end
                  end
               end
               default: state_q <= FS_SEARCH;
            endcase
         end
      end
   end
endmodule

// File: rtl/fsd_bi_vote.sv
module fsd_bi_vote #(
   parameter int VOTE_DEPTH = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic bi_sample,
   input  logic bit_in,
   output logic busy
);
   logic [VOTE_DEPTH-1:0] hist_q;

   always_ff @(posedge clk) begin
      if (rst)
         hist_q <= '0;
      else if (bi_sample)
         hist_q <= {hist_q[VOTE_DEPTH-2:0], bit_in};
   end

   generate
      if (VOTE_DEPTH == 3) begin : g_vote3
         assign busy = (hist_q[0] & hist_q[1]) | (hist_q[0] & hist_q[2]) |
                       (hist_q[1] & hist_q[2]);
      end else begin : g_voten
         assign busy = ($countones(hist_q) > (VOTE_DEPTH / 2));
      end
   endgenerate
endmodule

// File: rtl/fsd_frame_sync.sv
module fsd_frame_sync #(
   parameter int                  SYNC_LEN     = 11,
   parameter logic [SYNC_LEN-1:0] SYNC_WORD    = 11'b11100010010,
   parameter int                  CTRL_PERIOD  = 463,
   parameter int                  VOICE_PERIOD = 88,
   parameter int                  CTRL_MISSES  = 5,
   parameter int                  VOICE_MISSES = 2,
   parameter int                  BI_SPACING   = 11,
   parameter int                  VOTE_DEPTH   = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_en,
   input  logic bit_in,
   input  logic voice_mode,
   output logic locked,
   output logic sync_strobe,
   output logic frame_start,
   output logic busy_status
);
   generate
      if (SYNC_LEN < 2) begin : g_bad_len
         $error("SYNC_LEN must be at least 2");
      end
      if (CTRL_PERIOD <= SYNC_LEN || VOICE_PERIOD <= SYNC_LEN) begin : g_bad_period
         $error("frame periods must exceed the sync word length");
      end
      if (CTRL_MISSES < 1 || VOICE_MISSES < 1) begin : g_bad_miss
         $error("miss limits must be at least 1");
      end
      if (BI_SPACING < 1) begin : g_bad_spacing
         $error("BI_SPACING must be at least 1");
      end
      if (VOTE_DEPTH < 3 || (VOTE_DEPTH % 2) == 0) begin : g_bad_vote
         $error("VOTE_DEPTH must be odd and at least 3");
      end
   endgenerate

   logic match;
   logic bi_sample;

   fsd_sync_match #(
      .SYNC_LEN (SYNC_LEN),
      .SYNC_WORD(SYNC_WORD)
   ) u_match (
      .clk   (clk),
      .rst   (rst),
      .bit_en(bit_en),
      .bit_in(bit_in),
      .match (match)
   );

   fsd_frame_ctrl #(
      .CTRL_PERIOD (CTRL_PERIOD),
      .VOICE_PERIOD(VOICE_PERIOD),
      .CTRL_MISSES (CTRL_MISSES),
      .VOICE_MISSES(VOICE_MISSES),
      .BI_SPACING  (BI_SPACING)
   ) u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .bit_en     (bit_en),
      .voice_mode (voice_mode),
      .match      (match),
      .locked     (locked),
      .sync_strobe(sync_strobe),
      .frame_start(frame_start),
      .bi_sample  (bi_sample)
   );

   fsd_bi_vote #(
      .VOTE_DEPTH(VOTE_DEPTH)
   ) u_vote (
      .clk      (clk),
      .rst      (rst),
      .bi_sample(bi_sample),
      .bit_in   (bit_in),
      .busy     (busy_status)
   );
endmodule

// File: rtl/fsd_frame_sync_chk.sv
module fsd_frame_sync_chk (
   input logic clk,
   input logic rst,
   input logic bit_en,
   input logic locked,
   input logic sync_strobe,
   input logic frame_start,
   input logic busy_status
);
   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (!locked && !busy_status && !sync_strobe && !frame_start));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !bit_en |=> ($stable(locked) && $stable(busy_status) && !sync_strobe && !frame_start));

   // R6
   frame_when_locked_chk: assert property (@(posedge clk) disable iff (rst)
      frame_start |-> locked);

   // R3
   lock_entry_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(locked) |-> (sync_strobe && frame_start));

   // R5
   quiet_drop_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(locked) |-> (!frame_start && !sync_strobe));
endmodule

bind fsd_frame_sync fsd_frame_sync_chk u_chk (
   .clk        (clk),
   .rst        (rst),
   .bit_en     (bit_en),
   .locked     (locked),
   .sync_strobe(sync_strobe),
   .frame_start(frame_start),
   .busy_status(busy_status)
);

// File: tb/fsd_frame_sync_tb.sv
`timescale 1ns/1ps
module fsd_frame_sync_tb;
   localparam logic [10:0] PAT = 11'b11100010010;
   localparam int CFILL = 463 - 11;
   localparam int VFILL = 88 - 11;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bit_en = 1'b0;
   logic bit_in = 1'b0;
   logic voice_mode = 1'b0;
   logic locked, sync_strobe, frame_start, busy_status;

   int checks = 0;
   int errors = 0;
   int n_sync = 0;
   int n_frame = 0;
   int gap = 0;
   logic last_strobe = 1'b0;
   logic last_frame = 1'b0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   fsd_frame_sync u_dut (
      .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
      .voice_mode(voice_mode), .locked(locked), .sync_strobe(sync_strobe),
      .frame_start(frame_start), .busy_status(busy_status)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic vm);
      voice_mode = vm;
      rst = 1'b1; bit_en = 1'b0; bit_in = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
   endtask

   task automatic send_bit(input logic b);
      bit_in = b; bit_en = 1'b1;
      @(posedge clk); #1;
      last_strobe = sync_strobe;
      last_frame  = frame_start;
      if (sync_strobe) n_sync++;
      if (frame_start) n_frame++;
      if (gap > 0) begin
         bit_en = 1'b0; bit_in = ~b;
         for (int g = 0; g < gap; g++) begin
            @(posedge clk); #1;
            if (sync_strobe || frame_start) chk("R10 strobe in idle cycle", 1, 0);
         end
      end
   endtask

   task automatic send_sync(input logic good);
      for (int i = 10; i >= 0; i--) send_bit(good ? PAT[i] : 1'b0);
   endtask

   // offsets count from the bit after the reference word; busy/idle slot k at offset 1+11k
   task automatic send_fill(input int n, input int off0, input logic [63:0] mask, input logic noise);
      for (int i = 0; i < n; i++) begin
         int off = off0 + i;
         if (((off - 1) % 11) == 0 && ((off - 1) / 11) < 64) send_bit(mask[(off - 1) / 11]);
         else send_bit(noise);
      end
   endtask

   task automatic ctrl_frame(input logic good, input logic [63:0] mask, input logic noise);
      send_fill(CFILL, 1, mask, noise);
      send_sync(good);
   endtask

   task automatic acquire_ctrl();
      do_reset(1'b0);
      send_sync(1'b1);
      send_fill(CFILL, 1, 64'd0, 1'b0);
      send_sync(1'b1);
   endtask

   task automatic t_reset();
      do_reset(1'b0);
      chk("R1 locked after reset", locked, 0);
      chk("R1 busy after reset", busy_status, 0);
      chk("R1 strobes after reset", sync_strobe | frame_start, 0);
   endtask

   task automatic t_lock_ctrl();
      do_reset(1'b0);
      send_sync(1'b1);
      chk("R2 strobe on first word", last_strobe, 1);
      chk("R3 not locked after one word", locked, 0);
      send_fill(CFILL, 1, 64'd0, 1'b0);
      send_sync(1'b1);
      chk("R3 locked after 463-bit spacing", locked, 1);
      chk("R6 frame_start on lock entry", last_frame, 1);
   endtask

   task automatic t_spacing();
      do_reset(1'b0);
      send_sync(1'b1);
      send_fill(CFILL - 1, 1, 64'd0, 1'b0);
      send_sync(1'b1);
      chk("R3 early word does not lock", locked, 0);
      chk("R2 early word still strobes", last_strobe, 1);
      send_fill(CFILL, 1, 64'd0, 1'b0);
      send_sync(1'b1);
      chk("R3 restarted wait locks", locked, 1);
      do_reset(1'b0);
      send_sync(1'b1);
      send_fill(CFILL + 1, 1, 64'd0, 1'b0);
      send_sync(1'b1);
      chk("R3 late word does not lock", locked, 0);
   endtask

   task automatic t_offpos();
      int n0;
      acquire_ctrl();
      n0 = n_sync;
      send_fill(100, 1, 64'd0, 1'b0);
      send_sync(1'b1);
      send_fill(CFILL - 111, 112, 64'd0, 1'b0);
      chk("R4 off-position word ignored", n_sync - n0, 0);
      send_sync(1'b1);
      chk("R4 expected word accepted", last_strobe, 1);
      chk("R4 still locked", locked, 1);
   endtask

   task automatic t_miss();
      int f0;
      acquire_ctrl();
      f0 = n_frame;
      for (int k = 0; k < 4; k++) ctrl_frame(1'b0, 64'd0, 1'b0);
      chk("R5 four misses keep lock", locked, 1);
      chk("R6 frame_start on tolerated misses", n_frame - f0, 4);
      ctrl_frame(1'b1, 64'd0, 1'b0);
      for (int k = 0; k < 4; k++) ctrl_frame(1'b0, 64'd0, 1'b0);
      chk("R5 hit clears miss run", locked, 1);
      f0 = n_frame;
      ctrl_frame(1'b0, 64'd0, 1'b0);
      chk("R5 fifth miss drops lock", locked, 0);
      chk("R6 no frame_start on drop", n_frame - f0, 0);
   endtask

   task automatic t_busy();
      do_reset(1'b0);
      for (int i = 0; i < 30; i++) send_bit(1'b1);
      chk("R7 no sampling while hunting", busy_status, 0);
      acquire_ctrl();
      chk("R8 busy low after lock", busy_status, 0);
      send_fill(1, 1, 64'd1, 1'b0);
      chk("R8 one of three set", busy_status, 0);
      send_fill(11, 2, 64'd3, 1'b0);
      chk("R7 first two slots sampled, R8 busy", busy_status, 1);
      send_fill(11, 13, 64'd0, 1'b1);
      chk("R8 history 110 busy", busy_status, 1);
      send_fill(CFILL - 23, 24, 64'd0, 1'b1);
      chk("R7 noise bits ignored, R8 idle", busy_status, 0);
      send_sync(1'b1);
      ctrl_frame(1'b1, (64'd1 << 39) | (64'd1 << 40), 1'b0);
      chk("R8 last three 1,1,0", busy_status, 1);
      ctrl_frame(1'b1, (64'd1 << 41), 1'b1);
      chk("R8 last three 0,0,1", busy_status, 0);
      ctrl_frame(1'b1, (64'd1 << 39) | (64'd1 << 41), 1'b0);
      chk("R8 last three 1,0,1", busy_status, 1);
   endtask

   task automatic t_voice();
      do_reset(1'b1);
      send_sync(1'b1);
      send_fill(CFILL, 1, 64'd0, 1'b0);
      send_sync(1'b1);
      chk("R9 control spacing does not lock in voice mode", locked, 0);
      do_reset(1'b1);
      send_sync(1'b1);
      send_fill(VFILL, 1, 64'd0, 1'b0);
      send_sync(1'b1);
      chk("R9 locked after 88-bit spacing", locked, 1);
      send_fill(VFILL, 1, {64{1'b1}}, 1'b1);
      send_sync(1'b1);
      chk("R9 no busy sampling in voice mode", busy_status, 0);
      send_fill(VFILL, 1, 64'd0, 1'b0);
      send_sync(1'b0);
      chk("R9 one miss keeps lock", locked, 1);
      send_fill(VFILL, 1, 64'd0, 1'b0);
      send_sync(1'b0);
      chk("R9 second miss drops lock", locked, 0);
   endtask

   task automatic t_gap();
      gap = 2;
      do_reset(1'b0);
      send_sync(1'b1);
      chk("R10 word with idle gaps detected", last_strobe, 1);
      send_fill(CFILL, 1, 64'd0, 1'b0);
      send_sync(1'b1);
      chk("R10 idle cycles do not count as bits", locked, 1);
      gap = 0;
   endtask

   initial begin
      t_reset();
      t_lock_ctrl();
      t_spacing();
      t_offpos();
      t_miss();
      t_busy();
      t_voice();
      t_gap();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule